// File: doc/BRIEF.md
# 16-to-1 Serial Line Transmitter

This block turns a stream of 16-bit parallel words into a one-bit serial stream, one bit per rising edge of a fast bit clock. From the bit clock it derives a word clock at one sixteenth of the bit rate. The upstream logic uses the falling edge of that word clock as its word-transfer point. The word present on the parallel input at the bit-clock edge where the word clock falls is captured, and its first bit appears on the serial output at that same edge. The remaining fifteen bits follow on the next fifteen edges, and the next word follows with no idle bit in between.

A static order input picks which end of the word goes out first. An active-low squelch input holds the serial output at zero without disturbing the internal word framing, so when squelch is released the stream resumes at the correct bit position of the word in flight.

Top module: `ser16_tx`

## Requirements
- R1: Every captured word leaves as exactly 16 consecutive serial bits, one per bit-clock rising edge, and the first bit of the next word follows the last bit of the previous one with no gap.
- R2: With `msb_first` = 0 at the capture edge, `word_in[0]` is sent first, then `word_in[1]`, and so on up to `word_in[15]`.
- R3: With `msb_first` = 1 at the capture edge, `word_in[15]` is sent first, then `word_in[14]`, and so on down to `word_in[0]`.
- R4: If `squelch_n` is 0 at a bit-clock rising edge, `ser_out` is 0 after that edge. If it is 1, `ser_out` carries the scheduled data bit.
- R5: `word_clk` has a period of 16 bit clocks, made of 8 cycles high and 8 cycles low.
- R6: The word on `word_in` is captured at the rising edge where `word_clk` goes from 1 to 0, and its first bit appears on `ser_out` after that same edge.
- R7: Squelch gates only the output. Bit counting and word capture go on while squelched, so the bits after release sit at their normal positions in the word.
- R8: While `rst_n` is 0, `ser_out` and `word_clk` are 0. The first rising edge after release captures a word, and `word_clk` then stays low for 8 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_in | input | 16 | Parallel word, captured when word_clk falls |
| msb_first | input | 1 | Transmit order: 0 sends bit 0 first, 1 sends bit 15 first |
| squelch_n | input | 1 | Active-low squelch: 0 forces ser_out to 0 |
| ser_out | output | 1 | Serial data, registered on the bit clock |
| word_clk | output | 1 | Bit clock divided by 16, 50% duty |

## Verification
On every cycle, the assertions check that squelch zeroes the next output bit and that the word clock holds each level for exactly eight edges. They also check that the word clock is low after each capture edge, that the first bit after a capture is the correct end of the word for the selected order, and that the outputs are zero after a reset edge. Only the bench scenarios can show the full sixteen-bit order inside each word, the absence of gaps across long runs of back-to-back words, and the correct positions of the bits that follow a squelch window in the middle of a word.

// File: rtl/ser16_tx.sv
module ser16_tx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_in,
  input  logic              msb_first,
  input  logic              squelch_n,
  output logic              ser_out,
  output logic              word_clk
);
  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);
  localparam logic [CW-1:0] HALF = CW'(WORD_W / 2);

  logic [CW-1:0]     bit_cnt, cnt_nxt;
  logic [WORD_W-1:0] shreg, rev, ordered;
  logic              wrap, next_bit;

  for (genvar i = 0; i < WORD_W; i++) begin : g_rev
    assign rev[i] = word_in[WORD_W-1-i];
  end

  assign ordered  = msb_first ? rev : word_in;
  assign wrap     = (bit_cnt == LAST);
  assign cnt_nxt  = wrap ? '0 : bit_cnt + CW'(1);
  assign next_bit = wrap ? ordered[0] : shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= LAST;
      shreg    <= '0;
      ser_out  <= 1'b0;
      word_clk <= 1'b0;
    end else begin
      bit_cnt  <= cnt_nxt;
      shreg    <= wrap ? (ordered >> 1) : (shreg >> 1);
      ser_out  <= next_bit & squelch_n;
      word_clk <= (cnt_nxt >= HALF);
    end
  end
endmodule

module ser16_tx_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] word_in,
  input logic              msb_first,
  input logic              squelch_n,
  input logic              ser_out,
  input logic              word_clk,
  input logic [$clog2(WORD_W)-1:0] bit_cnt
);
  localparam logic [$clog2(WORD_W)-1:0] LAST = $clog2(WORD_W)'(WORD_W - 1);

  logic       prev_wclk, seen;
  logic [7:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_wclk <= 1'b0;
      seen      <= 1'b0;
      run_len   <= 8'd0;
    end else begin
      prev_wclk <= word_clk;
      if (word_clk != prev_wclk) begin
        run_len <= 8'd1;
        seen    <= 1'b1;
      end else if (run_len != 8'hFF) begin
        run_len <= run_len + 8'd1;
      end
    end
  end

  p_squelch_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !squelch_n |=> !ser_out);

  p_half_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && word_clk != prev_wclk) |-> run_len == 8'(WORD_W / 2));

  p_capture_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == LAST) |=> !word_clk);

  p_first_lsb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == LAST && squelch_n && !msb_first) |=> ser_out == $past(word_in[0]));

  p_first_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == LAST && squelch_n && msb_first) |=> ser_out == $past(word_in[WORD_W-1]));

  p_reset_quiet_r8: assert property (@(posedge clk)
    !rst_n |=> (!ser_out && !word_clk));
endmodule

bind ser16_tx ser16_tx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_in(word_in), .msb_first(msb_first),
  .squelch_n(squelch_n), .ser_out(ser_out), .word_clk(word_clk), .bit_cnt(bit_cnt)
);

// File: tb/test_ser16_tx.sv
module test_ser16_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] word_in = 16'hFFFF;
  logic        msb_first = 1'b0;
  logic        squelch_n = 1'b1;
  logic        ser_out, word_clk;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  ser16_tx i_ser16_tx (
    .clk(clk), .rst_n(rst_n), .word_in(word_in), .msb_first(msb_first),
    .squelch_n(squelch_n), .ser_out(ser_out), .word_clk(word_clk)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Entered at a falling edge just before a capture edge; leaves at the
  // falling edge before the next capture edge. sq_mask[k]=1 squelches bit k.
  task automatic send_word(input logic [15:0] w, input logic msb, input logic [15:0] sq_mask);
    word_in   = w;
    msb_first = msb;
    squelch_n = !sq_mask[0];
    for (int k = 0; k < 16; k++) begin
      logic exp_bit;
      @(posedge clk);
      @(negedge clk);
      exp_bit = sq_mask[k] ? 1'b0 : (msb ? w[15-k] : w[k]);
      if (sq_mask[k])
        check(ser_out == 1'b0, "R4 squelched bit", ser_out, 0);
      else if (sq_mask != 16'h0)
        check(ser_out == exp_bit, "R7 bit after squelch", ser_out, exp_bit);
      else if (msb)
        check(ser_out == exp_bit, "R3 R1 msb-first bit", ser_out, exp_bit);
      else
        check(ser_out == exp_bit, "R2 R1 lsb-first bit", ser_out, exp_bit);
      check(word_clk == (k >= 8), (k == 0) ? "R6 word_clk low at capture" : "R5 word_clk phase",
            word_clk, (k >= 8));
      if (k < 15) squelch_n = !sq_mask[k+1];
      else squelch_n = 1'b1;
    end
  endtask

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    check(ser_out == 1'b0, "R8 ser_out in reset", ser_out, 0);
    check(word_clk == 1'b0, "R8 word_clk in reset", word_clk, 0);
    @(negedge clk);
    check(ser_out == 1'b0 && word_clk == 1'b0, "R8 outputs held in reset", ser_out, 0);
    rst_n = 1'b1;
    // first edge after release captures (R8)
    send_word(16'h8001, 1'b0, 16'h0);
    for (int o = 0; o < 2; o++) begin
      for (int b = 0; b < 16; b++) send_word(16'h1 << b, o[0], 16'h0);
      send_word(16'hFFFF, o[0], 16'h0);
      send_word(16'h0000, o[0], 16'h0);
      send_word(16'hA5C3, o[0], 16'h0);
    end
    lfsr = 16'hACE1;
    for (int n = 0; n < 24; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send_word(lfsr, lfsr[3], 16'h0);
    end
    send_word(16'hFFFF, 1'b0, 16'h03F0);
    send_word(16'h5A3C, 1'b1, 16'h0);
    send_word(16'hFFFF, 1'b1, 16'hFFFF);
    send_word(16'hC3A5, 1'b0, 16'h0);
    send_word(16'hBEEF, 1'b1, 16'hF00F);
    send_word(16'h1234, 1'b1, 16'h0);
    // squelch spanning a word boundary
    send_word(16'hFFFF, 1'b0, 16'hC000);
    send_word(16'hFFFF, 1'b0, 16'h0003);
    send_word(16'h0F0F, 1'b0, 16'h0);
    // reset in mid-word, then restart
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(ser_out == 1'b0 && word_clk == 1'b0, "R8 outputs after mid-word reset", ser_out, 0);
    rst_n = 1'b1;
    send_word(16'h00FF, 1'b1, 16'h0);
    send_word(16'h7E81, 1'b0, 16'h0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule